// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage for an 8-bit accumulator datapath. Each cycle it takes an operation code, the accumulator value, a second operand, a carry input and the current flag byte. It registers three outputs: an 8-bit result, a new flag byte and an accumulator write enable. The flag byte holds sign, zero, nibble carry, even parity and carry. Each class of operation has its own rule for which of these it changes. Compare only updates the flags, and the write enable tells the surrounding datapath to leave the accumulator alone.

A single shared adder handles add, subtract, compare, increment and decrement. Logic operations and rotates have their own small units. The register file, instruction decode and memory access all sit outside the block.

Top module: `acc_alu`

## Requirements
- R1: All outputs are registered. A value presented before a rising clock edge appears on the outputs after that edge. While `rst_n` is low, `res_q` is 00h, `flag_q` is 02h and `acc_we_q` is 0.
- R2: The operation codes are ADD=0, ADC=1, SUB=2, SBB=3. The results are a+b, a+b+`cy_in`, a-b and a-b-`cy_in`, each modulo 256.
- R3: CMP=4 sets the flags exactly as SUB does and drives `res_q` = a with `acc_we_q` = 0. Every other defined code (0 to 13) drives `acc_we_q` = 1.
- R4: INC=5 gives a+1 and DEC=6 gives a-1. Both copy the carry bit of `flag_in` to the carry bit of `flag_q`.
- R5: AND=7, OR=8 and XOR=9 give the bitwise result of a and b. They clear both the carry flag and the nibble-carry flag.
- R6: The rotate codes are as follows. RLW=10 rotates left and wraps bit 7 into bit 0. RRW=11 rotates right and wraps bit 0 into bit 7. RLC=12 rotates left through carry, so the old carry enters bit 0. RRC=13 rotates right through carry, so the old carry enters bit 7. The old carry is bit 0 of `flag_in`. In every rotate, the bit shifted out becomes the new carry.
- R7: A rotate copies the sign, zero, nibble-carry and parity bits of `flag_in` unchanged.
- R8: For arithmetic, compare, increment, decrement and logic operations, sign equals bit 7 of the result, and zero is set exactly when the result is 00h. For compare, the result used is a-b.
- R9: For the same operations as R8, parity is set when the result has an even number of ones.
- R10: The nibble carry is handled per class. On ADD, ADC and INC it is the carry out of bit 3. On SUB, SBB, CMP and DEC it is the borrow into bit 3, meaning the low nibble of a is less than the low nibble of b plus the borrow in.
- R11: The carry flag is the carry out of bit 7 on ADD and ADC. On SUB, SBB and CMP it is the borrow, meaning a < b + borrow in.
- R12: The flag byte layout is sign bit 7, zero bit 6, nibble carry bit 4, parity bit 2 and carry bit 0. Bits 5 and 3 are always 0, and bit 1 is always 1. Codes 14 and 15 are no-ops: `res_q` = a, the flags equal `flag_in` with the fixed bits forced, and `acc_we_q` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| acc_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand |
| cy_in | input | 1 | Carry or borrow input for ADC and SBB |
| flag_in | input | 8 | Current flag byte |
| res_q | output | 8 | Registered result |
| flag_q | output | 8 | Registered new flag byte |
| acc_we_q | output | 1 | Registered accumulator write enable |

## Verification
All three outputs change on the first rising edge after an operation is presented, so every result is due exactly one cycle later. The bench drives the inputs on the falling edge and samples on the next falling edge, which is half a cycle after the registering edge and before any new input takes effect. Each vector is compared there against a reference function of the inputs. The assertions use the same one-cycle relation, through `|=>` and `$past` of depth one.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
        OP_CMP = 4'd4,  OP_INC = 4'd5,  OP_DEC = 4'd6,  OP_AND = 4'd7,
        OP_OR  = 4'd8,  OP_XOR = 4'd9,  OP_RLW = 4'd10, OP_RRW = 4'd11,
        OP_RLC = 4'd12, OP_RRC = 4'd13, OP_NP0 = 4'd14, OP_NP1 = 4'd15
    } alu_op_e;

    // flag byte bit positions
    localparam int FB_SIGN = 7;
    localparam int FB_ZERO = 6;
    localparam int FB_NIB  = 4;
    localparam int FB_PAR  = 2;
    localparam int FB_CY   = 0;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [7:0]        flags;
        logic              we;
    } alu_out_t;

    function automatic logic [7:0] pack_flags(input logic s, input logic z,
                                              input logic n, input logic p,
                                              input logic c);
        logic [7:0] f;
        f = 8'h02;
        f[FB_SIGN] = s;
        f[FB_ZERO] = z;
        f[FB_NIB]  = n;
        f[FB_PAR]  = p;
        f[FB_CY]   = c;
        return f;
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cb_in,   // carry (add) or borrow (subtract) in
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum,
    output logic             cb_out,  // carry (add) or borrow (subtract) out
    output logic             nib_cb   // same, at the nibble boundary
);
    localparam int NIB = WIDTH / 2;

    logic [WIDTH-1:0] b_eff;
    logic             c0;
    logic [NIB:0]     lo;
    logic [WIDTH:0]   full;

    always_comb begin
        b_eff  = do_sub ? ~b : b;
        c0     = do_sub ? ~cb_in : cb_in;
        lo     = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c0};
        full   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c0};
        sum    = full[WIDTH-1:0];
        cb_out = do_sub ? ~full[WIDTH] : full[WIDTH];
        nib_cb = do_sub ? ~lo[NIB] : lo[NIB];
    end
endmodule

// File: rtl/acc_alu_rot.sv
module acc_alu_rot #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             cy_old,
    input  logic             left,
    input  logic             thru,
    output logic [WIDTH-1:0] res,
    output logic             cy_new
);
    logic fill;

    always_comb begin
        if (left) begin
            fill   = thru ? cy_old : a[WIDTH-1];
            res    = {a[WIDTH-2:0], fill};
            cy_new = a[WIDTH-1];
        end else begin
            fill   = thru ? cy_old : a[0];
            res    = {fill, a[WIDTH-1:1]};
            cy_new = a[0];
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op,
    input  logic [DATA_W-1:0] acc_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic             cy_in,
    input  logic [7:0]       flag_in,
    output logic [DATA_W-1:0] res_q,
    output logic [7:0]       flag_q,
    output logic             acc_we_q
);
    alu_op_e  op_e;
    alu_out_t nx_d, st_q;

    logic [DATA_W-1:0] ar_b, ar_sum, rot_res, lg_res;
    logic              ar_cbin, ar_sub, ar_cb, ar_nib, rot_cy;
    logic              is_rot, rot_left, rot_thru;

    assign op_e = alu_op_e'(op);

    // operand steering for the shared adder
    always_comb begin
        ar_b    = opnd_b;
        ar_cbin = 1'b0;
        ar_sub  = 1'b0;
        unique case (op_e)
            OP_ADC:         ar_cbin = cy_in;
            OP_SUB, OP_CMP: ar_sub  = 1'b1;
            OP_SBB: begin ar_sub = 1'b1; ar_cbin = cy_in; end
            OP_INC: begin ar_b = '0; ar_cbin = 1'b1; end
            OP_DEC: begin ar_b = {{(DATA_W-1){1'b0}}, 1'b1}; ar_sub = 1'b1; end
            default: ;
        endcase
    end

    acc_alu_arith #(.WIDTH(DATA_W)) u_arith (
        .a(acc_a), .b(ar_b), .cb_in(ar_cbin), .do_sub(ar_sub),
        .sum(ar_sum), .cb_out(ar_cb), .nib_cb(ar_nib)
    );

    assign is_rot   = (op_e == OP_RLW) || (op_e == OP_RRW) ||
                      (op_e == OP_RLC) || (op_e == OP_RRC);
    assign rot_left = (op_e == OP_RLW) || (op_e == OP_RLC);
    assign rot_thru = (op_e == OP_RLC) || (op_e == OP_RRC);

    acc_alu_rot #(.WIDTH(DATA_W)) u_rot (
        .a(acc_a), .cy_old(flag_in[FB_CY]), .left(rot_left), .thru(rot_thru),
        .res(rot_res), .cy_new(rot_cy)
    );

    always_comb begin
        unique case (op_e)
            OP_AND:  lg_res = acc_a & opnd_b;
            OP_OR:   lg_res = acc_a | opnd_b;
            default: lg_res = acc_a ^ opnd_b;
        endcase
    end

    // next-state computation
    always_comb begin
        nx_d.res   = acc_a;
        nx_d.we    = 1'b1;
        nx_d.flags = pack_flags(flag_in[FB_SIGN], flag_in[FB_ZERO],
                                flag_in[FB_NIB], flag_in[FB_PAR], flag_in[FB_CY]);
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                nx_d.res   = ar_sum;
                nx_d.flags = pack_flags(ar_sum[DATA_W-1], ar_sum == '0, ar_nib,
                                        ~^ar_sum, ar_cb);
            end
            OP_CMP: begin
                nx_d.we    = 1'b0;
                nx_d.flags = pack_flags(ar_sum[DATA_W-1], ar_sum == '0, ar_nib,
                                        ~^ar_sum, ar_cb);
            end
            OP_INC, OP_DEC: begin
                nx_d.res   = ar_sum;
                nx_d.flags = pack_flags(ar_sum[DATA_W-1], ar_sum == '0, ar_nib,
                                        ~^ar_sum, flag_in[FB_CY]);
            end
            OP_AND, OP_OR, OP_XOR: begin
                nx_d.res   = lg_res;
                nx_d.flags = pack_flags(lg_res[DATA_W-1], lg_res == '0, 1'b0,
                                        ~^lg_res, 1'b0);
            end
            OP_RLW, OP_RRW, OP_RLC, OP_RRC: begin
                nx_d.res   = rot_res;
                nx_d.flags = pack_flags(flag_in[FB_SIGN], flag_in[FB_ZERO],
                                        flag_in[FB_NIB], flag_in[FB_PAR], rot_cy);
            end
            default: nx_d.we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.res   <= '0;
            st_q.flags <= 8'h02;
            st_q.we    <= 1'b0;
        end else begin
            st_q <= nx_d;
        end
    end

    assign res_q    = st_q.res;
    assign flag_q   = st_q.flags;
    assign acc_we_q = st_q.we;

    logic cls_arith, cls_logic;
    assign cls_arith = (op <= 4'd6);
    assign cls_logic = (op >= 4'd7) && (op <= 4'd9);

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd4) |=> !acc_we_q && res_q == $past(acc_a)); // R3
    AST_INCDEC_KEEP_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd5 || op == 4'd6) |=> flag_q[0] == $past(flag_in[0])); // R4
    AST_LOGIC_CLR_CY: assert property (@(posedge clk) disable iff (!rst_n)
        cls_logic |=> !flag_q[0] && !flag_q[4]); // R5
    AST_ROT_KEEP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        is_rot |=> flag_q[7:1] == ($past(flag_in[7:1]) & 7'b1101010 | 7'b0000001)); // R7
    AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_arith && op != 4'd4 || cls_logic) |=>
        flag_q[7] == res_q[7] && flag_q[6] == (res_q == '0)); // R8
    AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_arith && op != 4'd4 || cls_logic) |=> flag_q[2] == ~^res_q); // R9
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !flag_q[5] && !flag_q[3] && flag_q[1]); // R12
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] acc_a = '0, opnd_b = '0, flag_in = '0;
    logic       cy_in = 1'b0;
    logic [7:0] res_q, flag_q;
    logic       acc_we_q;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    acc_alu uut (
        .clk(clk), .rst_n(rst_n), .op(op), .acc_a(acc_a), .opnd_b(opnd_b),
        .cy_in(cy_in), .flag_in(flag_in), .res_q(res_q), .flag_q(flag_q),
        .acc_we_q(acc_we_q)
    );

    function automatic logic [7:0] fmk(input bit s, input bit z, input bit n,
                                       input bit p, input bit c);
        return {s, z, 1'b0, n, 1'b0, p, 1'b1, c};
    endfunction

    function automatic bit par_even(input logic [7:0] v);
        int k = 0;
        for (int i = 0; i < 8; i++) k += v[i];
        return (k % 2) == 0;
    endfunction

    // reference: {we, flags, result}
    function automatic logic [16:0] model(input int o, input logic [7:0] a,
                                          input logic [7:0] b, input bit ci,
                                          input logic [7:0] f);
        int s, c;
        logic [7:0] r, fl;
        bit we, nb, cy;
        we = 1; r = a;
        fl = fmk(f[7], f[6], f[4], f[2], f[0]);
        case (o)
            0, 1: begin
                c = (o == 1) ? int'(ci) : 0;
                s = int'(a) + int'(b) + c;
                r = s[7:0];
                nb = (int'(a[3:0]) + int'(b[3:0]) + c) > 15;
                fl = fmk(r[7], r == 0, nb, par_even(r), s > 255);
            end
            2, 3, 4: begin
                c = (o == 3) ? int'(ci) : 0;
                s = int'(a) - int'(b) - c;
                nb = int'(a[3:0]) < int'(b[3:0]) + c;
                cy = int'(a) < int'(b) + c;
                fl = fmk(s[7], s[7:0] == 0, nb, par_even(s[7:0]), cy);
                if (o == 4) we = 0; else r = s[7:0];
            end
            5: begin
                r = a + 8'd1;
                fl = fmk(r[7], r == 0, a[3:0] == 4'hF, par_even(r), f[0]);
            end
            6: begin
                r = a - 8'd1;
                fl = fmk(r[7], r == 0, a[3:0] == 4'h0, par_even(r), f[0]);
            end
            7, 8, 9: begin
                r = (o == 7) ? (a & b) : (o == 8) ? (a | b) : (a ^ b);
                fl = fmk(r[7], r == 0, 0, par_even(r), 0);
            end
            10: begin r = {a[6:0], a[7]}; fl[0] = a[7]; end
            11: begin r = {a[0], a[7:1]}; fl[0] = a[0]; end
            12: begin r = {a[6:0], f[0]}; fl[0] = a[7]; end
            13: begin r = {f[0], a[7:1]}; fl[0] = a[0]; end
            default: we = 0;
        endcase
        return {we, fl, r};
    endfunction

    function automatic string tag_of(input int o);
        if (o <= 3) return "R2 R11";
        if (o == 4) return "R3";
        if (o <= 6) return "R4 R10";
        if (o <= 9) return "R5";
        if (o <= 13) return "R6 R7";
        return "R12";
    endfunction

    task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got we=%0b f=%02h r=%02h expected we=%0b f=%02h r=%02h",
                     tag, got[16], got[15:8], got[7:0], exp[16], exp[15:8], exp[7:0]);
        end
    endtask

    // drive at negedge, result due after next posedge: sample at following negedge
    task automatic run(input string tag, input int o, input logic [7:0] a,
                       input logic [7:0] b, input bit ci, input logic [7:0] f);
        op = 4'(o); acc_a = a; opnd_b = b; cy_in = ci; flag_in = f;
        @(negedge clk);
        chk(tag, {acc_we_q, flag_q, res_q}, model(o, a, b, ci, f));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5A17);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset", {acc_we_q, flag_q, res_q}, {1'b0, 8'h02, 8'h00});
        rst_n = 1'b1;
        // directed corners
        run("R2 R11 add wrap", 0, 8'hFF, 8'h01, 0, 8'h00);           // 00, Z AC CY
        run("R10 nibble carry", 0, 8'h0F, 8'h01, 0, 8'h00);
        run("R2 adc", 1, 8'h7F, 8'h00, 1, 8'h00);                    // 80 sign
        run("R11 borrow", 2, 8'h00, 8'h01, 0, 8'h00);
        run("R10 R11 sbb", 3, 8'h10, 8'h00, 1, 8'h00);
        run("R3 cmp equal", 4, 8'h42, 8'h42, 0, 8'h00);
        run("R3 cmp less", 4, 8'h05, 8'h42, 0, 8'hFF);
        run("R4 inc keep cy", 5, 8'hFF, 8'h00, 0, 8'h01);
        run("R4 dec keep cy", 6, 8'h00, 8'h00, 1, 8'h00);
        run("R5 and", 7, 8'hF0, 8'h0F, 0, 8'hFF);
        run("R5 R9 xor", 9, 8'h03, 8'h00, 0, 8'h00);
        run("R6 rlw", 10, 8'h81, 8'h00, 0, 8'h00);
        run("R6 rrc", 13, 8'h01, 8'h00, 0, 8'h01);
        run("R7 rlc keeps flags", 12, 8'h80, 8'h00, 0, 8'hD4);
        run("R8 R9 or", 8, 8'h00, 8'h00, 0, 8'h00);
        run("R12 noop", 14, 8'h33, 8'h44, 1, 8'hFF);
        run("R12 noop", 15, 8'h33, 8'h44, 1, 8'h00);
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            int o;
            o = int'($urandom_range(0, 15));
            run(tag_of(o), o, 8'($urandom), 8'($urandom), bit'($urandom_range(0, 1)),
                8'($urandom));
        end
        // R1 reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset", {acc_we_q, flag_q, res_q}, {1'b0, 8'h02, 8'h00});
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule